// File: doc/BRIEF.md
# Watchdog Timer with Rate Select

This block is a computer-operating-properly watchdog that runs from the bus clock. It chains a binary prescaler of 2^PRE_BITS stages into a post-divider whose ratio is 1, 4, 16 or 64, picked by a 2-bit rate code. Running software proves it is alive by pulsing a service strobe, which restarts the count. If the strobe does not arrive before the selected period has elapsed, the block raises a one-cycle reset request and then starts counting again.

The rate code is captured only while the watchdog is idle, meaning in reset or disabled. It then stays fixed until the watchdog returns to idle. The default `PRE_BITS = 15` gives the usual base division of 32768. For short simulations a smaller value can be used, and the rate encoding does not change. At a 2 MHz bus clock the four periods are about 16.4 ms, 65.5 ms, 262 ms and 1.05 s. At 1 MHz each of these doubles.

A three-state controller governs the counters:

- **IDLE**: the counters are held at zero and the rate code is sampled.
- **ARMED**: the counters run.
- **FIRE**: a single cycle in which the reset request is driven.

The transitions are:

- **arm** (IDLE→ARMED): enable is high.
- **disarm** (any→IDLE): enable is low.
- **kick** (ARMED→ARMED): a service strobe clears the counters.
- **expire** (ARMED→FIRE): terminal count is reached with no service.
- **restart** (FIRE→ARMED): the cycle after expire, with the counters at zero.

Top module: `cop_watchdog`

## Requirements
- R1: After reset the reset request output is 0, both counters are zero and the controller is in IDLE.
- R2: A rising edge of the clock that samples enable = 1 in IDLE is the arming edge. On that edge the rate code is captured and counting starts from zero on the next cycle.
- R3: The period is P = 2^PRE_BITS × ratio cycles. The ratio is 1 for rate code 2'b00, 4 for 2'b01, 16 for 2'b10 and 64 for 2'b11. The reset request is high in the cycle that follows the edge P cycles after the arming edge.
- R4: The reset request is high for exactly one clock cycle per expiry.
- R5: After an expiry the counters restart from zero, so consecutive requests without service are P + 1 cycles apart.
- R6: A service strobe sampled high while armed clears both counters. The next request then follows the edge P cycles after that strobe's edge, and regular service prevents any request.
- R7: While enable is 0 the counters stay at zero and no request is produced, and this takes priority over service. Re-arming after a disable counts a full period from zero.
- R8: Changing the rate code while armed has no effect on the period. A new code takes effect only through IDLE.
- R9: The PRE_BITS parameter sets the prescaler length without altering the rate-code encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_e | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Watchdog enable |
| rate_sel | input | 2 | Rate code: 00=÷1, 01=÷4, 10=÷16, 11=÷64 after the prescaler |
| service | input | 1 | Service strobe, sampled on each rising edge |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Wrong internal state shows up only as reset-request timing at the ports. A prescaler or post-divider that does not clear moves the next request earlier than P cycles after a service or arming edge. A latched rate code that drifts changes the spacing of the next pair of requests. A stuck FIRE state produces a request wider than one cycle on the very next cycle. Because of this, the bench predicts the exact cycle number of every request and flags any request that is early, late, extra or missing. A fault is therefore exposed within one period of the disturbing event.

// File: rtl/cop_wdt_pkg.sv
package cop_wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    localparam int RATE_W = 2;

endpackage

// File: rtl/cop_wdt_prescaler.sv
module cop_wdt_prescaler #(
    parameter int PRE_BITS = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                run,
    output logic [PRE_BITS-1:0] count,
    output logic                tick
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (run) begin
            count <= count + PRE_BITS'(1);
        end
    end

    // last count of the prescaler stage
    assign tick = run && (&count);

endmodule

// File: rtl/cop_wdt_postdiv.sv
module cop_wdt_postdiv
    import cop_wdt_pkg::*;
#(
    parameter int POST_W = 2 * ((1 << RATE_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic [POST_W-1:0] count,
    output logic              terminal
);

    logic [RATE_W:0]     shamt;
    logic [POST_W-1:0]   mask;

    // ratio - 1 = 4^rate - 1 : two mask bits per code step
    assign shamt = {rate, 1'b0};
    assign mask  = ~({POST_W{1'b1}} << shamt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (tick) begin
            count <= count + POST_W'(1);
        end
    end

    assign terminal = tick && (count == mask);

    AST_POST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= mask)); // R3

endmodule

// File: rtl/cop_wdt_ctrl.sv
module cop_wdt_ctrl
    import cop_wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              service,
    input  logic              terminal,
    input  logic [RATE_W-1:0] rate_in,
    output logic [RATE_W-1:0] rate_q,
    output logic              run,
    output logic              clr,
    output logic              req
);

    wd_state_e state_q, state_d;

    // next-state decision: disable > service > terminal
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  state_d = enable ? WD_ARMED : WD_IDLE;
            WD_ARMED: begin
                if (!enable)       state_d = WD_IDLE;
                else if (service)  state_d = WD_ARMED;
                else if (terminal) state_d = WD_FIRE;
                else               state_d = WD_ARMED;
            end
            WD_FIRE:  state_d = enable ? WD_ARMED : WD_IDLE;
            default:  state_d = WD_IDLE;
        endcase
    end

    // state register and rate capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WD_IDLE) begin
                rate_q <= rate_in;
            end
        end
    end

    // outputs
    always_comb begin
        run = (state_q == WD_ARMED);
        clr = (state_q != WD_ARMED) || !enable || service || terminal;
        req = (state_q == WD_FIRE);
    end

    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WD_IDLE) |=> $stable(rate_q)); // R8

endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
    import cop_wdt_pkg::*;
#(
    parameter int PRE_BITS = 15
) (
    input  logic              clk_e,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        rate_sel,
    input  logic              service,
    output logic              rst_req
);

    localparam int POST_W = 2 * ((1 << RATE_W) - 1);

    logic                run;
    logic                clr;
    logic                tick;
    logic                term_hit;
    logic [RATE_W-1:0]   rate_q;
    logic [PRE_BITS-1:0] pre_cnt;
    logic [POST_W-1:0]   post_cnt;

    cop_wdt_ctrl u_ctrl (
        .clk      (clk_e),
        .rst_n    (rst_n),
        .enable   (enable),
        .service  (service),
        .terminal (term_hit),
        .rate_in  (rate_sel),
        .rate_q   (rate_q),
        .run      (run),
        .clr      (clr),
        .req      (rst_req)
    );

    cop_wdt_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk   (clk_e),
        .rst_n (rst_n),
        .clr   (clr),
        .run   (run),
        .count (pre_cnt),
        .tick  (tick)
    );

    cop_wdt_postdiv #(.POST_W(POST_W)) u_post (
        .clk      (clk_e),
        .rst_n    (rst_n),
        .clr      (clr),
        .tick     (tick),
        .rate     (rate_q),
        .count    (post_cnt),
        .terminal (term_hit)
    );

    AST_PULSE_ONE: assert property (@(posedge clk_e) disable iff (!rst_n)
        rst_req |=> !rst_req); // R4

    AST_FIRE_CAUSE: assert property (@(posedge clk_e) disable iff (!rst_n)
        rst_req |-> $past(term_hit && enable && !service)); // R3

    AST_SVC_CLEARS: assert property (@(posedge clk_e) disable iff (!rst_n)
        (enable && service) |=> (pre_cnt == '0 && post_cnt == '0)); // R6

    AST_OFF_QUIET: assert property (@(posedge clk_e) disable iff (!rst_n)
        !enable |=> (pre_cnt == '0 && post_cnt == '0 && !rst_req)); // R7

endmodule

// File: tb/tb_cop_watchdog.sv
module tb_cop_watchdog;

    localparam int PB   = 3;          // R9: shortened prescaler
    localparam int BASE = 1 << PB;

    typedef struct {
        int cyc;
        int req;
    } exp_t;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       enable = 0;
    logic [1:0] rate_sel = 2'b00;
    logic       service = 0;
    logic       rst_req;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    int   pulses = 0;
    logic prev_req = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    cop_watchdog #(.PRE_BITS(PB)) dut (
        .clk_e    (clk_e_w),
        .rst_n    (rst_n),
        .enable   (enable),
        .rate_sel (rate_sel),
        .service  (service),
        .rst_req  (rst_req)
    );

    wire clk_e_w = clk;

    function automatic int period(input int code);
        return BASE << (2 * code);
    endfunction

    task automatic push(input int c, input int r);
        exp_t e;
        e.cyc = c;
        e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (rst_req) begin
                pulses++;
                if (prev_req) begin
                    checks++; failures++;
                    $display("FAIL R4 actual=width>1 at cycle %0d expected=1", cyc);
                end
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R6/R7 actual=unexpected request at %0d expected=none", cyc);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (e.cyc != cyc) begin
                        failures++;
                        $display("FAIL R%0d actual=%0d expected=%0d", e.req, cyc, e.cyc);
                    end
                end
            end else if (prev_req) begin
                checks++; // R4 pulse ended after one cycle
            end
            prev_req = rst_req;
        end
    end

    // watchdog on the bench
    initial begin
        wait (cyc >= 100000);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c, p, snap, last_s;
        repeat (3) @(negedge clk);
        check(rst_req == 1'b0, "R1", rst_req, 0);
        rst_n = 1;
        repeat (20) @(negedge clk);
        check(pulses == 0, "R1", pulses, 0);

        // R2 R3 R5: each rate code, two expiries
        for (int code = 0; code < 4; code++) begin
            @(negedge clk);
            c = cyc;
            rate_sel = 2'(code);
            enable = 1;
            p = period(code);
            push(c + 1 + p, 3);
            push(c + 2 + 2 * p, 5);
            wait_until(c + 3 + 2 * p);
            enable = 0;
            repeat (2) @(negedge clk);
            check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        end

        // R6: service restarts the count
        @(negedge clk);
        c = cyc; rate_sel = 2'b01; enable = 1;
        wait_until(c + 20); service = 1; @(negedge clk); service = 0;
        wait_until(c + 45); service = 1; @(negedge clk); service = 0;
        push(c + 46 + period(1), 6);
        wait_until(c + 50 + period(1));
        enable = 0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6", exp_q.size(), 0);

        // R6: regular service prevents any request
        @(negedge clk);
        rate_sel = 2'b00; enable = 1;
        snap = pulses;
        last_s = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); service = 1; last_s = cyc + 1;
            @(negedge clk); service = 0;
            repeat (3) @(negedge clk);
        end
        check(pulses == snap, "R6", pulses - snap, 0);
        push(last_s + period(0), 6);
        wait_until(last_s + period(0) + 2);
        enable = 0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6", exp_q.size(), 0);

        // R7: disable mid-count, service while disabled, re-arm
        @(negedge clk);
        c = cyc; rate_sel = 2'b10; enable = 1;
        wait_until(c + 60);
        enable = 0;
        snap = pulses;
        for (int i = 0; i < 60; i++) begin
            service = ~service;
            repeat (5) @(negedge clk);
        end
        service = 0;
        check(pulses == snap, "R7", pulses - snap, 0);
        @(negedge clk);
        c = cyc; rate_sel = 2'b00; enable = 1;
        push(c + 1 + period(0), 7);
        wait_until(c + 3 + period(0));
        enable = 0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R7", exp_q.size(), 0);

        // R8: rate change while armed is ignored
        @(negedge clk);
        c = cyc; rate_sel = 2'b00; enable = 1;
        @(negedge clk);
        rate_sel = 2'b11;
        push(c + 1 + period(0), 8);
        push(c + 2 + 2 * period(0), 8);
        wait_until(c + 3 + 2 * period(0));
        enable = 0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        @(negedge clk);
        c = cyc; enable = 1;   // code 11 now captured through IDLE
        push(c + 1 + period(3), 8);
        wait_until(c + 3 + period(3));
        enable = 0;
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule